// File: doc/BRIEF.md
# Synchronous Serial Character Transmitter

This block drives one serial data line with characters of a programmable width, shifting one bit on each cycle in which the serial clock enable is high. After it is enabled, the line carries idle characters (all ones) until a sync event has armed the transmitter and a character is waiting on its input. Characters arrive through a valid/ready handshake from the buffer controller that feeds it. That controller also receives a character-boundary pulse, which it uses as its polling tick, and an underrun pulse.

Two line modes exist. In dedicated-pin mode, the transmitter advances on every serial clock enable once it is enabled. In time-slot mode, it advances only while the slot-enable input is high, so a character can be spread over several slots. A bit-order input selects between sending the least significant bit first and sending the most significant bit first. The transmitter loads a new character only at a character boundary. The character length and the bit order are expected to stay constant while the block is enabled.

Top module: `ser_tx_top`

## Requirements
- R1: While reset is asserted, or while en_i is low, txd_o is 1 and char_tick_o, tx_ready_o and underrun_o are 0.
- R2: A bit step is a cycle with en_i high, bit_en_i high and (slot_mode_i low or slot_act_i high). Counting from enable, char_tick_o goes high for one cycle, in the cycle after every N-th bit step. N is char_len_i clamped to the range 4..16, so values below 4 act as 4.
- R3: Until sync_i has been seen high while enabled, tx_ready_o stays 0 and txd_o stays 1, even when tx_valid_i is high.
- R4: Once synchronized, a character is accepted at a bit step that ends a character, when tx_valid_i and tx_ready_o are both high. With msb_first_i at 0, the accepted character is sent as bits 0 to N-1 of tx_data_i, one bit per following bit step and starting in the cycle after acceptance.
- R5: With msb_first_i at 1, bit N-1 of tx_data_i is sent first and bit 0 is sent last.
- R6: In time-slot mode (slot_mode_i at 1), a cycle with slot_act_i at 0 leaves txd_o unchanged and produces no char_tick_o.
- R7: If a character boundary passes with no accepted character, and the last accepted character had tx_last_i at 0, then underrun_o pulses for exactly one cycle and the next character is idle. If that last character had tx_last_i at 1, there is no underrun.
- R8: Synchronization holds until en_i falls. After en_i rises again, no character is accepted until sync_i has been seen once more.
- R9: tx_ready_o is high only in bit-step cycles that end a character while synchronized. Bits of tx_data_i at position N and above are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable; low clears sync and state |
| bit_en_i | input | 1 | Serial clock enable, one bit per high cycle |
| char_len_i | input | 5 | Character length, 4..16 |
| msb_first_i | input | 1 | 1 sends the most significant bit first |
| slot_mode_i | input | 1 | 1 selects time-slot gating |
| slot_act_i | input | 1 | Slot active, used in time-slot mode |
| sync_i | input | 1 | Sync or frame-sync event that arms transmission |
| tx_data_i | input | 16 | Character word, low N bits used |
| tx_last_i | input | 1 | Character ends the message |
| tx_valid_i | input | 1 | Character available |
| tx_ready_o | output | 1 | Character taken at this clock edge |
| txd_o | output | 1 | Serial data line |
| char_tick_o | output | 1 | One-cycle character boundary pulse |
| underrun_o | output | 1 | One-cycle underrun pulse |

## Verification
The assertions check properties that must hold on every cycle: the sync flag drops after a disable, a cycle with the slot inactive produces no bit step, the line stays idle while unsynchronized, the first bit after a load matches the selected bit order, and each underrun lasts only one cycle. The bench scenarios cover behaviour that depends on a sequence of events. This includes the tick spacing for several lengths and enable patterns, the complete bit streams of back-to-back characters, how underrun differs from a clean end of message, the line held still during an inactive slot, and the need to see sync again after a re-enable.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int MIN_CHAR_LEN = 4;

  typedef enum logic [1:0] {
    LOAD_NONE  = 2'd0,
    LOAD_IDLE  = 2'd1,
    LOAD_DATA  = 2'd2
  } load_kind_e;
endpackage

// File: rtl/ser_tx_step_gen.sv
module ser_tx_step_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_en_i,
  input  logic slot_mode_i,
  input  logic slot_act_i,
  input  logic sync_i,
  output logic step_o,
  output logic synced_o
);
  logic synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       synced_q <= 1'b0;
    else if (!en_i)    synced_q <= 1'b0;
    else if (sync_i)   synced_q <= 1'b1;
  end

  assign step_o   = en_i & bit_en_i & (~slot_mode_i | slot_act_i);
  assign synced_o = synced_q;

  assert_sync_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !synced_o);
  assert_slot_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_mode_i && !slot_act_i) |-> !step_o);
endmodule

// File: rtl/ser_tx_char_cnt.sv
module ser_tx_char_cnt #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] len_eff_o,
  output logic             boundary_o,
  output logic             tick_o
);
  import ser_tx_pkg::*;

  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_CHAR_LEN);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_eff;
  logic             tick_q;

  always_comb begin
    if (len_i < LEN_MIN)      len_eff = LEN_MIN;
    else if (len_i > LEN_MAX) len_eff = LEN_MAX;
    else                      len_eff = len_i;
  end

  assign boundary_o = step_i & (cnt_q == len_eff - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= boundary_o;
      if (!en_i)           cnt_q <= '0;
      else if (boundary_o) cnt_q <= '0;
      else if (step_i)     cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign len_eff_o = len_eff;
  assign tick_o    = tick_q;

  assert_tick_after_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(step_i));
  assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              step_i,
  input  logic              boundary_i,
  input  logic              synced_i,
  input  logic [LEN_W-1:0]  len_eff_i,
  input  logic              msb_first_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              underrun_o
);
  import ser_tx_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] ordered;
  logic              pending_q;
  logic              underrun_q;
  logic              accept;
  load_kind_e        load_kind;

  assign ready_o = boundary_i & synced_i;
  assign accept  = ready_o & valid_i;

  // place the character so that bit 0 of the register goes out first
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      logic [IDX_W-1:0] idx;
      idx = IDX_W'(int'(len_eff_i) - 1 - i);
      if (i < int'(len_eff_i)) ordered[i] = msb_first_i ? data_i[idx] : data_i[i];
      else                     ordered[i] = 1'b1;
    end
  end

  always_comb begin
    if (!boundary_i) load_kind = LOAD_NONE;
    else if (accept) load_kind = LOAD_DATA;
    else             load_kind = LOAD_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '1;
      pending_q  <= 1'b0;
      underrun_q <= 1'b0;
    end else if (!en_i) begin
      shreg_q    <= '1;
      pending_q  <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      underrun_q <= 1'b0;
      case (load_kind)
        LOAD_DATA: begin
          shreg_q   <= ordered;
          pending_q <= ~last_i;
        end
        LOAD_IDLE: begin
          shreg_q    <= '1;
          underrun_q <= pending_q;
          pending_q  <= 1'b0;
        end
        default: if (step_i) shreg_q <= {1'b1, shreg_q[DATA_W-1:1]};
      endcase
    end
  end

  assign txd_o      = shreg_q[0];
  assign underrun_o = underrun_q;

  logic first_msb;
  assign first_msb = data_i[IDX_W'(int'(len_eff_i) - 1)];

  assert_idle_unsynced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!synced_i && !$past(synced_i)) |-> txd_o);
  assert_first_lsb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && en_i && !msb_first_i) |=> txd_o == $past(data_i[0]));
  assert_first_msb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && en_i && msb_first_i) |=> txd_o == $past(first_msb));
  assert_underrun_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_en_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic              msb_first_i,
  input  logic              slot_mode_i,
  input  logic              slot_act_i,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_last_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  output logic              char_tick_o,
  output logic              underrun_o
);
  logic             step;
  logic             synced;
  logic             boundary;
  logic [LEN_W-1:0] len_eff;

  ser_tx_step_gen u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .bit_en_i    (bit_en_i),
    .slot_mode_i (slot_mode_i),
    .slot_act_i  (slot_act_i),
    .sync_i      (sync_i),
    .step_o      (step),
    .synced_o    (synced)
  );

  ser_tx_char_cnt #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .step_i     (step),
    .len_i      (char_len_i),
    .len_eff_o  (len_eff),
    .boundary_o (boundary),
    .tick_o     (char_tick_o)
  );

  ser_tx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .step_i      (step),
    .boundary_i  (boundary),
    .synced_i    (synced),
    .len_eff_i   (len_eff),
    .msb_first_i (msb_first_i),
    .data_i      (tx_data_i),
    .last_i      (tx_last_i),
    .valid_i     (tx_valid_i),
    .ready_o     (tx_ready_o),
    .txd_o       (txd_o),
    .underrun_o  (underrun_o)
  );

  assert_ready_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (en_i && bit_en_i));
  assert_off_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (txd_o && !underrun_o));
endmodule

// File: tb/ser_tx_top_tb_top.sv
module ser_tx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, bit_en = 1'b1, msb_first = 1'b0;
  logic        slot_mode = 1'b0, slot_act = 1'b0, sync = 1'b0;
  logic [4:0]  char_len = 5'd8;
  logic [15:0] tx_data = '0;
  logic        tx_last = 1'b0, tx_valid = 1'b0;
  logic        tx_ready, txd, char_tick, underrun;

  int checks = 0, errors = 0;
  int cycle = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cycle++;

  ser_tx_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bit_en_i(bit_en),
    .char_len_i(char_len), .msb_first_i(msb_first), .slot_mode_i(slot_mode),
    .slot_act_i(slot_act), .sync_i(sync), .tx_data_i(tx_data),
    .tx_last_i(tx_last), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .txd_o(txd), .char_tick_o(char_tick), .underrun_o(underrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  task automatic go_off();
    @(negedge clk);
    en = 0; tx_valid = 0; sync = 0; slot_mode = 0; slot_act = 0;
    msb_first = 0; bit_en = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sync_pulse();
    sync = 1; @(negedge clk); sync = 0;
  endtask

  task automatic xfer(input logic [15:0] d, input logic last, input int n,
                      input logic msb, input string req);
    int guard = 0;
    tx_data = d; tx_last = last; tx_valid = 1;
    while (!tx_ready && guard < 100) begin @(negedge clk); guard++; end
    chk(tx_ready, req, tx_ready, 1);
    @(posedge clk); #1 tx_valid = 0;
    for (int i = 0; i < n; i++) begin
      logic e;
      @(negedge clk);
      e = msb ? d[n-1-i] : d[i];
      chk(txd == e, req, txd, e);
    end
  endtask

  task automatic t_reset();  // R1
    chk(txd == 1 && !char_tick && !tx_ready && !underrun, "R1 reset",
        {txd, char_tick, tx_ready, underrun}, 8);
  endtask

  task automatic tick_span(input logic [4:0] len, input bit toggle, input int span,
                           input string req);
    int last_t = -1, n_t = 0;
    char_len = len; en = 1;
    for (int c = 0; c < 6 * span; c++) begin
      if (toggle) bit_en = c[0];
      @(negedge clk);
      if (char_tick) begin
        if (last_t >= 0) chk(cycle - last_t == span, req, cycle - last_t, span);
        last_t = cycle; n_t++;
      end
    end
    chk(n_t >= 5, req, n_t, 5);
    go_off();
  endtask

  task automatic t_tick();  // R2
    tick_span(5'd7, 1'b0, 7, "R2 len7");
    tick_span(5'd7, 1'b1, 14, "R2 len7 half-rate");
    tick_span(5'd2, 1'b0, 4, "R2 clamp low");
    tick_span(5'd16, 1'b0, 16, "R2 len16");
  endtask

  task automatic t_unsynced();  // R3
    bit bad_rdy = 0, bad_txd = 0;
    char_len = 5'd4; en = 1; tx_data = 16'h0000; tx_valid = 1;
    repeat (40) begin
      @(negedge clk);
      if (tx_ready) bad_rdy = 1;
      if (!txd) bad_txd = 1;
    end
    chk(!bad_rdy, "R3 no ready before sync", bad_rdy, 0);
    chk(!bad_txd, "R3 idle before sync", bad_txd, 0);
    go_off();
  endtask

  task automatic t_lsb();  // R4 R9
    char_len = 5'd4; en = 1; @(negedge clk);
    sync_pulse();
    xfer(16'hFFF6, 1'b0, 4, 1'b0, "R4/R9 lsb upper bits ignored");
    xfer(16'h0009, 1'b1, 4, 1'b0, "R4 lsb back-to-back");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(txd == 1 && !underrun, "R7 clean end idle", {txd, underrun}, 2);
    end
    go_off();
  endtask

  task automatic t_msb();  // R5
    char_len = 5'd12; msb_first = 1; en = 1; @(negedge clk);
    sync_pulse();
    xfer(16'hFA53, 1'b0, 12, 1'b1, "R5 msb len12");
    xfer(16'h0C81, 1'b1, 12, 1'b1, "R5 msb second");
    go_off();
  endtask

  task automatic t_slot();  // R6
    int guard = 0;
    char_len = 5'd4; slot_mode = 1; slot_act = 1; en = 1; @(negedge clk);
    sync_pulse();
    tx_data = 16'h000A; tx_last = 1; tx_valid = 1;
    while (!tx_ready && guard < 50) begin @(negedge clk); guard++; end
    chk(tx_ready, "R6 slot ready", tx_ready, 1);
    @(posedge clk); #1 tx_valid = 0;
    @(negedge clk);
    chk(txd == 0, "R6 slot bit0", txd, 0);
    slot_act = 0;
    repeat (5) begin
      @(negedge clk);
      chk(txd == 0 && !char_tick, "R6 held in inactive slot", {txd, char_tick}, 0);
    end
    slot_act = 1;
    @(negedge clk); chk(txd == 1, "R6 slot bit1", txd, 1);
    @(negedge clk); chk(txd == 0, "R6 slot bit2", txd, 0);
    @(negedge clk); chk(txd == 1, "R6 slot bit3", txd, 1);
    go_off();
  endtask

  task automatic t_underrun();  // R7
    char_len = 5'd5; en = 1; @(negedge clk);
    sync_pulse();
    xfer(16'h0015, 1'b0, 5, 1'b0, "R7 pre-underrun char");
    @(negedge clk);
    chk(underrun == 1, "R7 underrun pulse", underrun, 1);
    chk(txd == 1, "R7 idle after underrun", txd, 1);
    @(negedge clk);
    chk(underrun == 0, "R7 underrun one cycle", underrun, 0);
    go_off();
  endtask

  task automatic t_resync();  // R8
    bit bad = 0;
    char_len = 5'd4; en = 1; @(negedge clk);
    sync_pulse();
    repeat (6) @(negedge clk);
    xfer(16'h0003, 1'b1, 4, 1'b0, "R8 sync persists");
    en = 0; repeat (2) @(negedge clk);
    en = 1; tx_data = 16'h0000; tx_valid = 1;
    repeat (30) begin
      @(negedge clk);
      if (tx_ready || !txd) bad = 1;
    end
    chk(!bad, "R8 re-enable needs sync", bad, 0);
    tx_valid = 0;
    sync_pulse();
    xfer(16'h0005, 1'b1, 4, 1'b0, "R8 after resync");
    go_off();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_unsynced();
    t_lsb();
    t_msb();
    t_slot();
    t_underrun();
    t_resync();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule